// File: doc/BRIEF.md
# Self-Synchronizing Cell Payload Scrambler

This block scrambles or descrambles a bit-serial cell stream with a 43-stage self-synchronizing shift register whose generator is x^43+1. Each payload bit is XORed with the bit held in the last stage. That stage holds the value shifted in 43 payload steps earlier. In scramble mode the scrambled result is shifted back into the register. In descramble mode the received line bit is shifted in instead. Because of this, a receiver that is fed the scrambled stream locks onto the sender after 43 payload bits, without any seed being agreed between the two ends.

Every input item carries a payload flag. Header bits (flag low) pass through unchanged and leave the register untouched. Only payload bits advance the register. The mode pin is quasi-static: it should change only while no item is being accepted. Items enter through a valid/ready input and leave through a valid/ready output. The output is a single register stage with one clock of latency.

Back-pressure rules: an input item is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output item stays unchanged and no new item is accepted. `in_valid` may be held high for any number of cycles, and an item is never dropped or duplicated.

Top module: `cellscr_top`

## Requirements
- R1: A synchronous active-high reset clears all 43 stages to zero and drops `out_valid`; after reset, payload bits of value 0 in scramble mode produce output 0.
- R2: In scramble mode (`descr_mode` = 0), the output for each accepted payload bit is that bit XORed with the 43rd-oldest stage value.
- R3: In scramble mode, the scrambled output bit is what shifts into the first stage, so every output bit equals the input bit XOR the output produced 43 payload bits earlier.
- R4: In descramble mode (`descr_mode` = 1), the output is the received bit XOR the last stage, and the received bit itself shifts into the first stage.
- R5: An accepted item with `in_payload` = 0 appears unchanged at the output, and all 43 stages keep their values.
- R6: An item accepted on clock edge N is presented with `out_valid` high after edge N and before edge N+1; with no further input and `out_ready` high, `out_valid` falls after edge N+1.
- R7: While `out_valid` is high and `out_ready` is low, `out_bit` and `out_valid` hold and `in_ready` is low; no item is lost or repeated.
- R8: A descrambler in any state that receives a scrambler's line bits returns the original data from the 44th payload bit onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| descr_mode | input | 1 | 0 = scramble, 1 = descramble |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an input item |
| in_bit | input | 1 | Data or line bit |
| in_payload | input | 1 | 1 = payload bit (scrambled), 0 = header bit (passed through) |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Consumer takes the output item |
| out_bit | output | 1 | Scrambled, descrambled or passed-through bit |

## Verification
The assertions check on every cycle that the XOR is taken with the last stage, that the right bit (result or received bit) enters the first stage for the current mode, and that header bits leave the register frozen. They also check that a stalled output holds still and that an accepted item shows up one cycle later. Only the bench scenarios show behaviour that spans many items. These are the 43-bit recurrence over long payload runs, the state surviving an embedded header gap, and lossless ordering under irregular back-pressure. They also include the descrambler locking from an arbitrary state onto a stream made by an independent scrambler model.

// File: rtl/cellscr_pkg.sv
package cellscr_pkg;

  typedef enum logic {
    MODE_SCRAMBLE   = 1'b0,
    MODE_DESCRAMBLE = 1'b1
  } cellscr_mode_e;

  // Payload bits are mixed with the tap; header bits pass unchanged.
  function automatic logic mix_bit(logic d, logic tap, logic pay);
    return pay ? (d ^ tap) : d;
  endfunction

endpackage

// File: rtl/cellscr_stages.sv
module cellscr_stages #(
  parameter int DEPTH = 43
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic feed_bit,
  output logic tap_bit,
  output logic head_bit
);
  localparam int TAP_IDX = DEPTH - 1;

  logic [DEPTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst)
      stage_q <= '0;
    else if (shift_en)
      stage_q <= {stage_q[TAP_IDX-1:0], feed_bit};
  end

  assign tap_bit  = stage_q[TAP_IDX];
  assign head_bit = stage_q[0];

  // R1: reset empties every stage
  assert_clear_R1: assert property (@(posedge clk) rst |=> stage_q == '0);

  // R5: without a payload shift the register is frozen
  assert_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(stage_q));

  // R3: each stage takes the previous stage's old value on a shift
  assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> stage_q[TAP_IDX:1] == $past(stage_q[TAP_IDX-1:0]));

endmodule

// File: rtl/cellscr_mix.sv
module cellscr_mix
  import cellscr_pkg::*;
(
  input  logic in_bit,
  input  logic tap_bit,
  input  logic payload,
  input  logic mode_bit,
  output logic res_bit,
  output logic feed_bit
);
  cellscr_mode_e mode;

  always_comb begin
    mode     = cellscr_mode_e'(mode_bit);
    res_bit  = mix_bit(in_bit, tap_bit, payload);
    feed_bit = (mode == MODE_DESCRAMBLE) ? in_bit : res_bit;
  end

endmodule

// File: rtl/cellscr_outstage.sv
module cellscr_outstage (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_bit,
  input  logic out_ready,
  output logic out_valid,
  output logic out_bit,
  output logic slot_free
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_bit   <= load_bit;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign slot_free = !out_valid || out_ready;

  // R1: reset drops the output item
  assert_empty_R1: assert property (@(posedge clk) rst |=> !out_valid);

  // R7: a stalled item holds its value
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R6: a loaded item is presented on the next cycle
  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> out_valid);

endmodule

// File: rtl/cellscr_top.sv
module cellscr_top #(
  parameter int DEPTH = 43
) (
  input  logic clk,
  input  logic rst,
  input  logic descr_mode,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_payload,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit
);
  logic accept;
  logic shift_en;
  logic tap_bit;
  logic head_bit;
  logic res_bit;
  logic feed_bit;
  logic slot_free;

  assign in_ready = slot_free;
  assign accept   = in_valid && slot_free;
  assign shift_en = accept && in_payload;

  cellscr_mix u_mix (
    .in_bit   (in_bit),
    .tap_bit  (tap_bit),
    .payload  (in_payload),
    .mode_bit (descr_mode),
    .res_bit  (res_bit),
    .feed_bit (feed_bit)
  );

  cellscr_stages #(.DEPTH(DEPTH)) u_stages (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .feed_bit (feed_bit),
    .tap_bit  (tap_bit),
    .head_bit (head_bit)
  );

  cellscr_outstage u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_bit  (res_bit),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .slot_free (slot_free)
  );

  // R2: scrambled output is input XOR last stage
  assert_scr_out_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && in_payload && !descr_mode) |=> out_bit == $past(in_bit ^ tap_bit));

  // R3: in scramble mode the output is what entered stage 0
  assert_scr_feed_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && in_payload && !descr_mode) |=> head_bit == out_bit);

  // R4: in descramble mode the received bit enters stage 0
  assert_dsc_feed_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && in_payload && descr_mode) |=>
      (head_bit == $past(in_bit)) && (out_bit == $past(in_bit ^ tap_bit)));

  // R5: header bits pass straight through
  assert_passthru_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_payload) |=> out_bit == $past(in_bit));

  // R7: no acceptance while the output is stalled
  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/cellscr_top_tb_top.sv
module cellscr_top_tb_top;
  localparam int N = 43;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic descr_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_payload = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready;
  logic out_valid;
  logic out_bit;

  always #10 clk = ~clk;

  cellscr_top #(.DEPTH(N)) dut_i (
    .clk(clk), .rst(rst), .descr_mode(descr_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .in_payload(in_payload), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit)
  );

  typedef struct {
    logic  exp;
    logic  plain;
    logic  chk_plain;
    string tag;
  } item_t;

  item_t       sbq[$];
  int          total = 0;
  int          bad = 0;
  logic [N-1:0] mhist = '0;   // model of the block's register
  logic [N-1:0] shist = '0;   // independent far-end scrambler
  logic [15:0] prng = 16'hACE1;
  bit          stall_mode = 1'b0;
  int          cyc = 0;
  bit          done = 1'b0;
  logic        prev_stall = 1'b0;
  logic        prev_bit = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic next_data();
    prng = {prng[14:0], prng[15] ^ prng[13] ^ prng[12] ^ prng[10]};
    return prng[0];
  endfunction

  // Driver: compute expectation, push it, drive the item until accepted.
  task automatic send(input logic b, input logic pay, input string tag,
                      input logic chk_plain = 1'b0, input logic plain = 1'b0);
    item_t it;
    logic e;
    if (pay) begin
      e = b ^ mhist[N-1];
      mhist = {mhist[N-2:0], (descr_mode ? b : e)};
    end else begin
      e = b;
    end
    it.exp = e; it.plain = plain; it.chk_plain = chk_plain; it.tag = tag;
    sbq.push_back(it);
    in_valid = 1'b1; in_bit = b; in_payload = pay;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    mhist = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Monitor: compare each output item as it is taken.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        check(out_valid == 1'b1, "R7", "valid held under stall", int'(out_valid), 1);
        check(out_bit == prev_bit, "R7", "bit held under stall", int'(out_bit), int'(prev_bit));
        check(in_ready == out_ready, "R7", "in_ready while occupied", int'(in_ready), int'(out_ready));
      end
      if (out_valid && out_ready) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R6", "unexpected output item", 1, 0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          check(out_bit == it.exp, it.tag, "output bit", int'(out_bit), int'(it.exp));
          if (it.chk_plain)
            check(out_bit == it.plain, "R8", "recovered data", int'(out_bit), int'(it.plain));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_bit   = out_bit;
    end else begin
      prev_stall = 1'b0;
    end
  end

  // Consumer ready pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = stall_mode ? (((cyc * 7) % 5) < 2) : 1'b1;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #1;

    // R1: zero state gives zero output for zero data
    for (int i = 0; i < 10; i++) send(1'b0, 1'b1, "R1");
    // R2 then R3: scramble recurrence over a long run
    for (int i = 0; i < 120; i++) send(next_data(), 1'b1, (i < N) ? "R2" : "R3");
    // R5: header gap in the middle, then payload continues from held state
    for (int i = 0; i < 8; i++) send(i[0], 1'b0, "R5");
    for (int i = 0; i < 60; i++) send(next_data(), 1'b1, "R5");
    drain();

    // R6: single item latency
    send(1'b1, 1'b0, "R6");
    @(negedge clk);
    check(out_valid == 1'b1, "R6", "valid one cycle after accept", int'(out_valid), 1);
    check(out_bit == 1'b1, "R6", "bit one cycle after accept", int'(out_bit), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R6", "valid drops when drained", int'(out_valid), 0);
    @(posedge clk); #1;

    // R7: irregular back-pressure, mixed header and payload
    stall_mode = 1'b1;
    for (int i = 0; i < 100; i++) send(next_data(), (i % 11) != 0, "R7");
    drain();
    stall_mode = 1'b0;
    drain();

    // R4: descramble from zero state
    do_reset();
    descr_mode = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 80; i++) send(next_data(), 1'b1, "R4");
    drain();

    // R8: lock from arbitrary state onto an independent scrambler
    shist = 43'h5A3C96E1F07;
    for (int i = 0; i < 120; i++) begin
      logic d, ln;
      d  = next_data();
      ln = d ^ shist[N-1];
      shist = {shist[N-2:0], ln};
      send(ln, 1'b1, "R8", (i >= N), d);
    end
    drain();

    check(sbq.size() == 0, "R7", "items left in scoreboard", sbq.size(), 0);
    finish_run();
  end

endmodule